// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads short-format translation descriptors from memory one word at a time and then checks whether the access is allowed. A request carries the address, a write flag, an access size and a privilege flag. It also carries an enable for translation and an enable for the alignment check. The caller also supplies two table base registers, a 3-bit split width, and two control bits that widen read permission, called "system" and "rom".

The block walks at most two levels. The first level resolves either a 1 MB section or a 16 MB supersection, or it points to a second-level table. The second level resolves a 64 KB large page or a 4 KB small page. When the walk ends, the block raises a one-cycle done pulse. The pulse carries the physical address and a fault code. Descriptor reads use a single-outstanding request/acknowledge port. There is no translation cache, so every request performs a full walk.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mem_req` are low.
- R2: With `mmu_en` low, an accepted request finishes with `pa` equal to the request address and fault code 0. No descriptor read and no alignment check take place.
- R3: Size codes are 0 byte, 1 halfword, 2 word and 3 (checked like a byte). With `align_en` high, a word with VA[1:0] nonzero or a halfword with VA[0] set ends with fault code 1, `pa` 0 and no descriptor read. Bytes never fault on alignment.
- R4: Let n = `ttb_split`. When n is nonzero and any of the top n VA bits is set, the first read address is `ttb_hi`[31:14] with VA[31:20] at bits [13:2]. Otherwise it is `ttb_lo` with bits below (14-n) cleared, ORed with VA[31-n:20] placed at bits [13-n:2]. Read addresses always have bits [1:0] equal to 0.
- R5: A first-level descriptor with bits [1:0] equal to 0 or 3 ends the walk with fault code 2.
- R6: Bits [1:0] equal to 2 mark a section, and its permission field is bits [11:10]. If descriptor bit 16 or bit 17 is set, `pa` is desc[31:24] joined with VA[23:0]. Otherwise `pa` is desc[31:20] joined with VA[19:0].
- R7: Bits [1:0] equal to 1 cause a second read at desc[31:10] joined with VA[19:12] and two zero bits. A second-level descriptor with bits [1:0] equal to 0 gives fault code 3.
- R8: A second-level type 1 gives `pa` = desc[31:16] joined with VA[15:0]. Types 2 and 3 give desc[31:12] joined with VA[11:0]. The permission field is bits [5:4].
- R9: Permission 3 allows everything, and permission 2 allows any read plus privileged writes. Permission 1 allows only privileged accesses. Permission 0 allows only reads, and only when (system and privileged) or rom.
- R10: A permission failure gives fault code 4 for a section or supersection and fault code 5 for a page. In both cases `pa` is 0.
- R11: `mem_req` stays high with a stable address until `mem_ack`, and is never high while the block is idle. A section walk makes exactly one read and a page walk makes exactly two.
- R12: `done` is a single-cycle pulse, and any nonzero fault comes with `pa` equal to 0. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_priv | input | 1 | 1 = privileged access |
| mmu_en | input | 1 | Translation enable |
| align_en | input | 1 | Alignment check enable |
| ttb_lo | input | 32 | Low-region table base |
| ttb_hi | input | 32 | High-region table base |
| ttb_split | input | 3 | Split width n |
| ctl_sys | input | 1 | System permission bit |
| ctl_rom | input | 1 | Rom permission bit |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| done | output | 1 | Result pulse |
| pa | output | 32 | Physical address |
| fault | output | 3 | 0 none, 1 align, 2 section xlate, 3 page xlate, 4 section perm, 5 page perm |

## Verification
A table of vectors drives one input pattern per translation path. These cover translation bypass, misalignment for each access size, both first-level fault encodings, a section, both supersection marker bits, all three second-level types and a second-level fault. Each permission value is tried with reads and writes, privileged and user, and with the system and rom bits. This separates the four-entry permission table from the section/page fault split. Split widths 0, 2 and 7 are used with addresses that fall on each side of the split. The bench memory answers only at the address it computes itself, so a wrong table base or wrong index shows up as a fault. Memory latency changes from vector to vector, and a directed test presents a second request during a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PTW_AW = 32;
    localparam int PTW_NW = 3;
    localparam int PTW_FW = 3;

    typedef enum logic [PTW_FW-1:0] {
        FLT_NONE      = 3'd0,
        FLT_ALIGN     = 3'd1,
        FLT_SEC_XLATE = 3'd2,
        FLT_PG_XLATE  = 3'd3,
        FLT_SEC_PERM  = 3'd4,
        FLT_PG_PERM   = 3'd5
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        DK_FAULT = 2'd0,
        DK_TABLE = 2'd1,
        DK_BLOCK = 2'd2
    } dkind_e;

    typedef struct packed {
        st_e               st;
        logic [PTW_AW-1:0] va;
        logic              wr;
        logic              priv;
        logic              sys;
        logic              rom;
        logic [PTW_AW-1:0] addr;
        logic [PTW_AW-1:0] pa;
        flt_e              flt;
    } walk_s;
endpackage

// File: rtl/ptw_l1_addr.sv
module ptw_l1_addr
    import ptw_pkg::*;
(
    input  logic [PTW_AW-1:0] va,
    input  logic [PTW_AW-1:0] ttb_lo,
    input  logic [PTW_AW-1:0] ttb_hi,
    input  logic [PTW_NW-1:0] split,
    output logic [PTW_AW-1:0] addr
);
    localparam logic [PTW_AW-1:0] ONES     = {PTW_AW{1'b1}};
    localparam logic [PTW_AW-1:0] HI_BASE  = ONES << 14;
    localparam logic [PTW_AW-1:0] WORD_MSK = ONES << 2;

    logic [PTW_AW-1:0] top_mask;
    logic              use_hi;
    logic [PTW_AW-1:0] base_lo;
    logic [PTW_AW-1:0] idx_lo;
    logic [PTW_AW-1:0] hi_addr;

    always_comb begin
        top_mask = ~(ONES >> split);
        use_hi   = (split != '0) && ((va & top_mask) != '0);
        base_lo  = ttb_lo & (ONES << (5'd14 - 5'(split)));
        idx_lo   = ((va << split) >> (5'd18 + 5'(split))) & WORD_MSK;
        hi_addr  = (ttb_hi & HI_BASE) | {18'b0, va[31:20], 2'b00};
        addr     = use_hi ? hi_addr : (base_lo | idx_lo);
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter bit LEVEL2 = 1'b0
) (
    input  logic [PTW_AW-1:0] desc,
    input  logic [PTW_AW-1:0] va,
    output dkind_e            kind,
    output logic [PTW_AW-1:0] pa,
    output logic [PTW_AW-1:0] next_addr,
    output logic [1:0]        ap
);
    generate
        if (LEVEL2) begin : g_l2
            logic unused_l2;
            assign unused_l2 = ^{desc[11:6], desc[3:2], va[31:16]};
            always_comb begin
                next_addr = '0;
                ap        = desc[5:4];
                kind      = DK_BLOCK;
                pa        = {desc[31:12], va[11:0]};
                case (desc[1:0])
                    2'd0: begin
                        kind = DK_FAULT;
                        pa   = '0;
                    end
                    2'd1: pa = {desc[31:16], va[15:0]};
                    default: ;
                endcase
            end
        end else begin : g_l1
            logic unused_l1;
            assign unused_l1 = ^{desc[15:12], desc[9:2], va[31:24]};
            always_comb begin
                next_addr = {desc[31:10], va[19:12], 2'b00};
                ap        = desc[11:10];
                pa        = '0;
                kind      = DK_FAULT;
                case (desc[1:0])
                    2'd1: kind = DK_TABLE;
                    2'd2: begin
                        kind = DK_BLOCK;
                        if (desc[17] || desc[16])
                            pa = {desc[31:24], va[23:0]};
                        else
                            pa = {desc[31:20], va[19:0]};
                    end
                    default: kind = DK_FAULT;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
    input  logic [1:0] ap,
    input  logic       is_write,
    input  logic       priv,
    input  logic       sys_bit,
    input  logic       rom_bit,
    output logic       allow
);
    always_comb begin
        case (ap)
            2'd0:    allow = !is_write && ((sys_bit && priv) || rom_bit);
            2'd1:    allow = priv;
            2'd2:    allow = !is_write || priv;
            default: allow = 1'b1;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_priv,
    input  logic              mmu_en,
    input  logic              align_en,
    input  logic [31:0]       ttb_lo,
    input  logic [31:0]       ttb_hi,
    input  logic [2:0]        ttb_split,
    input  logic              ctl_sys,
    input  logic              ctl_rom,
    output logic              busy,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [2:0]        fault
    ,
    output logic [31:0]       pa
);
    walk_s w_q, w_d;

    logic [PTW_AW-1:0] l1_addr;
    dkind_e            l1_kind, l2_kind;
    logic [PTW_AW-1:0] l1_pa, l2_pa, l1_next, unused_l2_next;
    logic [1:0]        l1_ap, l2_ap, ap_sel;
    logic              perm_ok;
    logic              misaligned;

    ptw_l1_addr u_l1_addr (
        .va     (req_va),
        .ttb_lo (ttb_lo),
        .ttb_hi (ttb_hi),
        .split  (ttb_split),
        .addr   (l1_addr)
    );

    ptw_desc_decode #(.LEVEL2(1'b0)) u_dec_l1 (
        .desc      (mem_rdata),
        .va        (w_q.va),
        .kind      (l1_kind),
        .pa        (l1_pa),
        .next_addr (l1_next),
        .ap        (l1_ap)
    );

    ptw_desc_decode #(.LEVEL2(1'b1)) u_dec_l2 (
        .desc      (mem_rdata),
        .va        (w_q.va),
        .kind      (l2_kind),
        .pa        (l2_pa),
        .next_addr (unused_l2_next),
        .ap        (l2_ap)
    );

    assign ap_sel = (w_q.st == ST_L2) ? l2_ap : l1_ap;

    ptw_perm u_perm (
        .ap       (ap_sel),
        .is_write (w_q.wr),
        .priv     (w_q.priv),
        .sys_bit  (w_q.sys),
        .rom_bit  (w_q.rom),
        .allow    (perm_ok)
    );

    assign misaligned = align_en &&
                        (((req_size == 2'd2) && (req_va[1:0] != 2'b00)) ||
                         ((req_size == 2'd1) && req_va[0]));

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.va   = req_va;
                    w_d.wr   = req_write;
                    w_d.priv = req_priv;
                    w_d.sys  = ctl_sys;
                    w_d.rom  = ctl_rom;
                    if (!mmu_en) begin
                        w_d.pa  = req_va;
                        w_d.flt = FLT_NONE;
                        w_d.st  = ST_DONE;
                    end else if (misaligned) begin
                        w_d.pa  = '0;
                        w_d.flt = FLT_ALIGN;
                        w_d.st  = ST_DONE;
                    end else begin
                        w_d.addr = l1_addr;
                        w_d.st   = ST_L1;
                    end
                end
            end
            ST_L1: begin
                if (mem_ack) begin
                    case (l1_kind)
                        DK_TABLE: begin
                            w_d.addr = l1_next;
                            w_d.st   = ST_L2;
                        end
                        DK_BLOCK: begin
                            w_d.pa  = perm_ok ? l1_pa : '0;
                            w_d.flt = perm_ok ? FLT_NONE : FLT_SEC_PERM;
                            w_d.st  = ST_DONE;
                        end
                        default: begin
                            w_d.pa  = '0;
                            w_d.flt = FLT_SEC_XLATE;
                            w_d.st  = ST_DONE;
                        end
                    endcase
                end
            end
            ST_L2: begin
                if (mem_ack) begin
                    w_d.st = ST_DONE;
                    if (l2_kind == DK_FAULT) begin
                        w_d.pa  = '0;
                        w_d.flt = FLT_PG_XLATE;
                    end else begin
                        w_d.pa  = perm_ok ? l2_pa : '0;
                        w_d.flt = perm_ok ? FLT_NONE : FLT_PG_PERM;
                    end
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: ST_IDLE, flt: FLT_NONE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign busy     = (w_q.st != ST_IDLE);
    assign mem_req  = (w_q.st == ST_L1) || (w_q.st == ST_L2);
    assign mem_addr = w_q.addr;
    assign done     = (w_q.st == ST_DONE);
    assign pa       = w_q.pa;
    assign fault    = w_q.flt;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_va,
    input logic [1:0]  req_size,
    input logic        mmu_en,
    input logic        align_en,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic [31:0] pa,
    input logic [2:0]  fault
);
    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11
    AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (fault != 3'd0)) |-> (pa == 32'd0)); // R12
    AST_ALIGN_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && mmu_en && align_en && (req_size == 2'd2) && (req_va[1:0] != 2'b00))
        |=> (done && !mem_req && (fault == 3'd1))); // R3
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !mmu_en)
        |=> (done && (fault == 3'd0) && (pa == $past(req_va)))); // R2
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    localparam logic [31:0] TTB_LO = 32'h8000_4000;
    localparam logic [31:0] TTB_HI = 32'h9000_8000;
    localparam logic [31:0] SEC    = 32'h4010_0C02;
    localparam logic [31:0] TBL    = 32'h0070_0401;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [1:0]  sz;
        logic        priv;
        logic        mmu;
        logic        aln;
        logic [2:0]  n;
        logic        s;
        logic        r;
        logic [31:0] l1d;
        logic [31:0] l2d;
        logic [31:0] pa;
        logic [2:0]  flt;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5679,0,2,1,0,1,0,0,0,SEC,0,32'h1234_5679,0},          // R2 bypass
        '{32'h0005_4322,0,2,1,1,1,0,0,0,SEC,0,0,1},                      // R3 word misaligned
        '{32'h0005_4321,0,1,1,1,1,0,0,0,SEC,0,0,1},                      // R3 half odd
        '{32'h0005_4321,0,0,1,1,1,0,0,0,SEC,0,32'h4015_4321,0},          // R3 byte, R6 section
        '{32'h0005_4322,0,2,1,1,0,0,0,0,SEC,0,32'h4015_4322,0},          // R3 check off
        '{32'h0005_4320,0,2,1,1,1,0,0,0,32'h0,0,0,2},                    // R5 type 0
        '{32'h0005_4320,0,2,1,1,1,0,0,0,32'h4010_0C03,0,0,2},            // R5 type 3
        '{32'h0234_5678,0,2,1,1,1,0,0,0,32'hAB01_0C02,0,32'hAB34_5678,0},// R6 bit 16
        '{32'h0111_1110,0,2,1,1,1,0,0,0,32'hCD02_0C02,0,32'hCD11_1110,0},// R6 bit 17
        '{32'h0003_4ABC,0,2,1,1,1,0,0,0,TBL,32'h5555_5032,32'h5555_5ABC,0}, // R8 small
        '{32'h0003_4ABC,0,2,1,1,1,0,0,0,TBL,32'h6666_0031,32'h6666_4ABC,0}, // R8 large
        '{32'h0003_4ABC,0,2,1,1,1,0,0,0,TBL,32'h7777_7033,32'h7777_7ABC,0}, // R8 type 3
        '{32'h0003_4ABC,0,2,1,1,1,0,0,0,TBL,32'h0000_0030,0,3},          // R7 page fault
        '{32'h8000_1234,0,2,1,1,1,2,0,0,SEC,0,32'h4010_1234,0},          // R4 high base
        '{32'h2010_0000,0,2,1,1,1,2,0,0,SEC,0,32'h4010_0000,0},          // R4 low, n=2
        '{32'h0100_0000,0,2,1,1,1,7,0,0,SEC,0,32'h4010_0000,0},          // R4 low, n=7
        '{32'h0000_1000,0,2,1,1,1,0,1,0,32'h4010_0002,0,32'h4010_1000,0},// R9 ap0 sys priv
        '{32'h0000_1000,0,2,0,1,1,0,1,0,32'h4010_0002,0,0,4},            // R9 ap0 user
        '{32'h0000_1000,0,2,0,1,1,0,0,1,32'h4010_0002,0,32'h4010_1000,0},// R9 ap0 rom
        '{32'h0000_1000,1,2,1,1,1,0,1,1,32'h4010_0002,0,0,4},            // R9 ap0 write
        '{32'h0000_1000,0,2,0,1,1,0,0,0,32'h4010_0402,0,0,4},            // R9 ap1 user
        '{32'h0000_1000,1,2,1,1,1,0,0,0,32'h4010_0402,0,32'h4010_1000,0},// R9 ap1 priv
        '{32'h0000_1000,0,2,0,1,1,0,0,0,32'h4010_0802,0,32'h4010_1000,0},// R9 ap2 read
        '{32'h0000_1000,1,2,0,1,1,0,0,0,32'h4010_0802,0,0,4},            // R10 ap2 user write
        '{32'h0000_1000,1,2,0,1,1,0,0,0,SEC,0,32'h4010_1000,0},          // R9 ap3
        '{32'h0003_4ABC,1,2,0,1,1,0,0,0,TBL,32'h5555_5022,0,5},          // R10 page
        '{32'h0003_4ABC,0,2,0,1,1,0,0,0,TBL,32'h5555_5012,0,5},          // R10 page ap1
        '{32'h0003_4ABC,1,2,0,1,1,0,0,0,TBL,32'h5555_5032,32'h5555_5ABC,0} // R9 page ap3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic req_write = 1'b0;
    logic [1:0] req_size = '0;
    logic req_priv = 1'b0;
    logic mmu_en = 1'b0;
    logic align_en = 1'b0;
    logic [2:0] ttb_split = '0;
    logic ctl_sys = 1'b0;
    logic ctl_rom = 1'b0;
    logic busy, mem_req, done;
    logic [31:0] mem_addr, pa;
    logic [2:0] fault;
    logic mem_ack;
    logic [31:0] mem_rdata;

    int errors = 0;
    int checks = 0;
    int lat = 0;
    int wait_cnt;
    int fetch_cnt;
    bit finished = 0;
    vec_t cur;

    always #2.5 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
        .mmu_en(mmu_en), .align_en(align_en), .ttb_lo(TTB_LO), .ttb_hi(TTB_HI),
        .ttb_split(ttb_split), .ctl_sys(ctl_sys), .ctl_rom(ctl_rom),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .fault(fault), .pa(pa)
    );

    function automatic logic [31:0] exp_l1(input logic [31:0] va, input logic [2:0] n);
        logic [31:0] lowmask;
        logic [31:0] idxmask;
        if (n != 0 && (va >> (32 - int'(n))) != 0)
            return {TTB_HI[31:14], va[31:20], 2'b00};
        lowmask = (32'h1 << (14 - int'(n))) - 1;
        idxmask = (32'h1 << (12 - int'(n))) - 1;
        return (TTB_LO & ~lowmask) | (((va >> 20) & idxmask) << 2);
    endfunction

    function automatic logic [31:0] mem_resp(input logic [31:0] a);
        if (a == exp_l1(cur.va, cur.n)) return cur.l1d;
        if (cur.l1d[1:0] == 2'd1 && a == {cur.l1d[31:10], cur.va[19:12], 2'b00}) return cur.l2d;
        return 32'h0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            wait_cnt <= 0;
            fetch_cnt <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_cnt >= lat) begin
                    mem_ack <= 1'b1;
                    mem_rdata <= mem_resp(mem_addr);
                    wait_cnt <= 0;
                    fetch_cnt <= fetch_cnt + 1;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int c = 0; c < 60; c++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    task automatic apply(input vec_t v);
        cur = v;
        req_va = v.va; req_write = v.wr; req_size = v.sz; req_priv = v.priv;
        mmu_en = v.mmu; align_en = v.aln; ttb_split = v.n;
        ctl_sys = v.s; ctl_rom = v.r;
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        int base;
        int exp_f;
        v = VECS[i];
        lat = i % 3;
        @(negedge clk);
        apply(v);
        base = fetch_cnt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        if (!v.mmu || v.flt == 3'd1) exp_f = 0;
        else if (v.l1d[1:0] == 2'd1) exp_f = 2;
        else exp_f = 1;
        check32($sformatf("R12 vector %0d done", i), 32'(done), 32'd1);
        check32($sformatf("R6 R8 vector %0d pa", i), pa, v.pa);
        check32($sformatf("R5 R7 R10 vector %0d fault", i), 32'(fault), 32'(v.flt));
        check32($sformatf("R11 vector %0d descriptor reads", i), 32'(fetch_cnt - base), 32'(exp_f));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int extra;
        cur = VECS[0];
        repeat (3) @(negedge clk);
        check32("R1 busy in reset", 32'(busy), 0);
        check32("R1 done in reset", 32'(done), 0);
        check32("R1 mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 busy after reset", 32'(busy), 0);
        check32("R1 mem_req after reset", 32'(mem_req), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R12: request presented mid-walk is ignored; done lasts one cycle
        lat = 2;
        @(negedge clk);
        apply(VECS[9]);
        req_valid = 1'b1;
        @(negedge clk);
        req_va = 32'hFFFF_FFFC; mmu_en = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        mmu_en = 1'b1;
        wait_done();
        check32("R12 busy request ignored pa", pa, 32'h5555_5ABC);
        check32("R12 busy request ignored fault", 32'(fault), 0);
        @(negedge clk);
        check32("R12 done single cycle", 32'(done), 0);
        extra = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check32("R12 no second result", 32'(extra), 0);
        check32("R11 idle no request", 32'(mem_req), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule